// File: doc/BRIEF.md
# Armed Cascaded-Delay Timing Channel

This block is one channel of a beam-synchronous timing generator. It runs on the bucket clock, where one clock cycle equals one RF bucket. Software or neighbouring logic arms it with a single-cycle pulse and opens or closes it with enable and disable strobes. Once the channel is both armed and enabled, a decoded reference event starts a delay. When the delay ends, the channel drives a fixed-width output pulse and disarms itself.

The delay is built from three stages in series. A coarse stage counts units of seven buckets from a 24-bit value. A bucket stage then adds zero to seven single buckets from a 3-bit value. A 5-bit nanosecond tap code is latched when timing starts and presented on an output, so that an external delay line can apply sub-bucket trim. The delay values are captured at the start of timing, so writes made during a count do not change the pulse already under way.

An optional fallback path covers a reference event that never arrives. If the channel is still waiting, armed and enabled when the end-of-cycle event comes, it emits a short direct pulse and disarms. An inhibit input aborts any activity and holds the output low.

Top module: `timing_channel`

## Requirements
- R1: After reset, chanPulse, timingActive and armed are all low and the channel is disabled.
- R2: A one-cycle armPulse sets armed, which reads high at the next cycle.
- R3: A refEvent starts timing only when the channel is armed and enabled in that cycle. Otherwise it is ignored, and timingActive and chanPulse stay low.
- R4: Let D = 7*delayCoarse + delayHigh. chanPulse first goes high D+1 cycles after timingActive first goes high. timingActive goes high in the cycle after refEvent is sampled.
- R5: timingActive stays high in every cycle from the start of timing until the pulse begins. It is never high together with chanPulse.
- R6: The normal output pulse is 56 cycles wide.
- R7: The start of the output pulse clears armed. A later refEvent with no new armPulse is ignored.
- R8: delayCoarse, delayHigh and delayFine are sampled when timing starts. fineTap shows the sampled delayFine and holds it until the next start. Changing the inputs during a count changes neither the delay nor fineTap.
- R9: With fallbackEn high, an endCycleEvent seen while the channel is idle, armed and enabled produces a direct pulse 5 cycles wide, starting the next cycle, and clears armed. With fallbackEn low, or when the channel is not armed, endCycleEvent is ignored.
- R10: While inhibit is high, chanPulse is low. Inhibit aborts a count in progress, so no pulse follows. Inhibit does not clear armed.
- R11: disableStrobe during a count returns the channel to idle with no pulse, and armed stays set. When disableStrobe and enableStrobe arrive in the same cycle, the channel is left disabled.
- R12: When refEvent and endCycleEvent arrive in the same cycle, the reference wins and a normal delayed pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bucket-rate clock |
| rstN | input | 1 | Asynchronous reset, active low |
| armPulse | input | 1 | One-cycle arm request |
| enableStrobe | input | 1 | Enables the channel |
| disableStrobe | input | 1 | Disables the channel and aborts a count |
| refEvent | input | 1 | Decoded reference event |
| endCycleEvent | input | 1 | Decoded end-of-cycle event |
| fallbackEn | input | 1 | Allows the direct fallback pulse |
| inhibit | input | 1 | Aborts activity and forces the output low |
| delayCoarse | input | 24 | Coarse delay in units of 7 buckets |
| delayHigh | input | 3 | Added single-bucket delay |
| delayFine | input | 5 | Nanosecond trim code |
| chanPulse | output | 1 | Channel output pulse |
| fineTap | output | 5 | Trim code latched at timing start |
| timingActive | output | 1 | High while the delay is counting |
| armed | output | 1 | Armed status |

## Verification
A coarse or bucket counter that is loaded or decremented wrongly shows up at the ports as a pulse edge moved by whole buckets, or by multiples of seven. The bench measures that edge from the first cycle of timingActive, so the error is visible within one delay. A width counter off by one stretches or shortens the pulse within 56 cycles. Arm and enable state that is wrong shows up on the next reference or end-of-cycle event, as a pulse that appears or goes missing. The captured tap code is compared after the inputs are changed in mid-count.

// File: rtl/chan_pkg.sv
package chan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_COARSE = 3'd1,
    ST_BUCKET = 3'd2,
    ST_PULSE  = 3'd3,
    ST_DIRECT = 3'd4
  } chan_state_e;

  typedef struct packed {
    logic loadDelay;
    logic runCoarse;
    logic runBucket;
    logic loadWidth;
    logic widthSel;   // 1 selects the direct (fallback) width
    logic runWidth;
  } chan_strobe_t;

endpackage

// File: rtl/chan_datapath.sv
module chan_datapath
  import chan_pkg::*;
#(
  parameter int COARSE_W     = 24,
  parameter int HIGH_W       = 3,
  parameter int FINE_W       = 5,
  parameter int UNIT_BUCKETS = 7,
  parameter int PULSE_WIDTH  = 56,
  parameter int DIRECT_WIDTH = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  chan_strobe_t        strb,
  input  logic [COARSE_W-1:0] delayCoarse,
  input  logic [HIGH_W-1:0]   delayHigh,
  input  logic [FINE_W-1:0]   delayFine,
  output logic                coarseZero,
  output logic                coarseDone,
  output logic                bucketDone,
  output logic                widthDone,
  output logic [FINE_W-1:0]   fineTap
);

  localparam int SUB_W   = (UNIT_BUCKETS > 1) ? $clog2(UNIT_BUCKETS) : 1;
  localparam int MAX_WID = (PULSE_WIDTH > DIRECT_WIDTH) ? PULSE_WIDTH : DIRECT_WIDTH;
  localparam int WIDTH_W = (MAX_WID > 1) ? $clog2(MAX_WID) : 1;

  logic [COARSE_W-1:0] coarseCnt;
  logic [SUB_W-1:0]    subCnt;
  logic [HIGH_W-1:0]   bucketCnt;
  logic [WIDTH_W-1:0]  widthCnt;
  logic [FINE_W-1:0]   fineTapQ;

  assign coarseZero = (delayCoarse == '0);
  assign coarseDone = (subCnt == '0) && (coarseCnt == COARSE_W'(1));
  assign bucketDone = (bucketCnt == '0);
  assign widthDone  = (widthCnt == '0);
  assign fineTap    = fineTapQ;

  // Coarse stage: counts units of UNIT_BUCKETS through a sub-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coarseCnt <= '0;
      subCnt    <= '0;
    end else if (strb.loadDelay) begin
      coarseCnt <= delayCoarse;
      subCnt    <= SUB_W'(UNIT_BUCKETS - 1);
    end else if (strb.runCoarse) begin
      if (subCnt == '0) begin
        subCnt    <= SUB_W'(UNIT_BUCKETS - 1);
        coarseCnt <= coarseCnt - COARSE_W'(1);
      end else begin
        subCnt <= subCnt - SUB_W'(1);
      end
    end
  end

  // Bucket stage and trim capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bucketCnt <= '0;
      fineTapQ  <= '0;
    end else if (strb.loadDelay) begin
      bucketCnt <= delayHigh;
      fineTapQ  <= delayFine;
    end else if (strb.runBucket) begin
      bucketCnt <= bucketCnt - HIGH_W'(1);
    end
  end

  // Output width counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthCnt <= '0;
    end else if (strb.loadWidth) begin
      widthCnt <= strb.widthSel ? WIDTH_W'(DIRECT_WIDTH - 1) : WIDTH_W'(PULSE_WIDTH - 1);
    end else if (strb.runWidth) begin
      widthCnt <= widthCnt - WIDTH_W'(1);
    end
  end

  AST_COARSE_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.runCoarse |-> coarseCnt != '0); // R4
  AST_BUCKET_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.runBucket |-> bucketCnt != '0); // R4
  AST_WIDTH_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.runWidth |-> widthCnt != '0); // R6
  AST_TAP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadDelay |=> $stable(fineTapQ)); // R8

endmodule

// File: rtl/chan_ctrl.sv
module chan_ctrl
  import chan_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         armPulse,
  input  logic         enableStrobe,
  input  logic         disableStrobe,
  input  logic         refEvent,
  input  logic         endCycleEvent,
  input  logic         fallbackEn,
  input  logic         inhibit,
  input  logic         coarseZero,
  input  logic         coarseDone,
  input  logic         bucketDone,
  input  logic         widthDone,
  output chan_strobe_t strb,
  output logic         timingActive,
  output logic         pulseActive,
  output logic         armed
);

  chan_state_e stateQ, stateD;
  logic armedQ, enabledQ, disarm, canFire;

  assign canFire      = armedQ && enabledQ;
  assign timingActive = (stateQ == ST_COARSE) || (stateQ == ST_BUCKET);
  assign pulseActive  = (stateQ == ST_PULSE) || (stateQ == ST_DIRECT);
  assign armed        = armedQ;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    disarm = 1'b0;
    if (inhibit) begin
      stateD = ST_IDLE;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (refEvent && canFire) begin
            strb.loadDelay = 1'b1;
            stateD = coarseZero ? ST_BUCKET : ST_COARSE;
          end else if (fallbackEn && endCycleEvent && canFire) begin
            strb.loadWidth = 1'b1;
            strb.widthSel  = 1'b1;
            disarm = 1'b1;
            stateD = ST_DIRECT;
          end
        end
        ST_COARSE: begin
          if (disableStrobe) begin
            stateD = ST_IDLE;
          end else begin
            strb.runCoarse = 1'b1;
            if (coarseDone) stateD = ST_BUCKET;
          end
        end
        ST_BUCKET: begin
          if (disableStrobe) begin
            stateD = ST_IDLE;
          end else if (bucketDone) begin
            strb.loadWidth = 1'b1;
            disarm = 1'b1;
            stateD = ST_PULSE;
          end else begin
            strb.runBucket = 1'b1;
          end
        end
        ST_PULSE, ST_DIRECT: begin
          if (widthDone) stateD = ST_IDLE;
          else strb.runWidth = 1'b1;
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      armedQ   <= 1'b0;
      enabledQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (disarm) armedQ <= 1'b0;
      else if (armPulse) armedQ <= 1'b1;
      if (disableStrobe) enabledQ <= 1'b0;
      else if (enableStrobe) enabledQ <= 1'b1;
    end
  end

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timingActive) |-> $past(refEvent && armedQ && enabledQ)); // R3
  AST_DISARM_ON_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseActive) |-> !armedQ); // R7
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(timingActive && pulseActive)); // R5
  AST_INHIBIT_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    inhibit |=> !timingActive && !pulseActive); // R10
  AST_DISABLE_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    (disableStrobe && timingActive && !inhibit) |=> stateQ == ST_IDLE); // R11

endmodule

// File: rtl/timing_channel.sv
module timing_channel #(
  parameter int COARSE_W     = 24,
  parameter int HIGH_W       = 3,
  parameter int FINE_W       = 5,
  parameter int UNIT_BUCKETS = 7,
  parameter int PULSE_WIDTH  = 56,
  parameter int DIRECT_WIDTH = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                armPulse,
  input  logic                enableStrobe,
  input  logic                disableStrobe,
  input  logic                refEvent,
  input  logic                endCycleEvent,
  input  logic                fallbackEn,
  input  logic                inhibit,
  input  logic [COARSE_W-1:0] delayCoarse,
  input  logic [HIGH_W-1:0]   delayHigh,
  input  logic [FINE_W-1:0]   delayFine,
  output logic                chanPulse,
  output logic [FINE_W-1:0]   fineTap,
  output logic                timingActive,
  output logic                armed
);

  chan_pkg::chan_strobe_t strb;
  logic coarseZero, coarseDone, bucketDone, widthDone, pulseActive;

  chan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .armPulse(armPulse), .enableStrobe(enableStrobe),
    .disableStrobe(disableStrobe), .refEvent(refEvent), .endCycleEvent(endCycleEvent),
    .fallbackEn(fallbackEn), .inhibit(inhibit), .coarseZero(coarseZero),
    .coarseDone(coarseDone), .bucketDone(bucketDone), .widthDone(widthDone),
    .strb(strb), .timingActive(timingActive), .pulseActive(pulseActive), .armed(armed)
  );

  chan_datapath #(
    .COARSE_W(COARSE_W), .HIGH_W(HIGH_W), .FINE_W(FINE_W),
    .UNIT_BUCKETS(UNIT_BUCKETS), .PULSE_WIDTH(PULSE_WIDTH), .DIRECT_WIDTH(DIRECT_WIDTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .delayCoarse(delayCoarse),
    .delayHigh(delayHigh), .delayFine(delayFine), .coarseZero(coarseZero),
    .coarseDone(coarseDone), .bucketDone(bucketDone), .widthDone(widthDone),
    .fineTap(fineTap)
  );

  assign chanPulse = pulseActive && !inhibit;

endmodule

// File: tb/timing_channel_tb.sv
module timing_channel_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic armPulse = 0, enableStrobe = 0, disableStrobe = 0;
  logic refEvent = 0, endCycleEvent = 0, fallbackEn = 0, inhibit = 0;
  logic [23:0] delayCoarse = '0;
  logic [2:0]  delayHigh = '0;
  logic [4:0]  delayFine = '0;
  logic chanPulse, timingActive, armed;
  logic [4:0] fineTap;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  timing_channel u_dut (
    .clk(clk), .rstN(rstN), .armPulse(armPulse), .enableStrobe(enableStrobe),
    .disableStrobe(disableStrobe), .refEvent(refEvent), .endCycleEvent(endCycleEvent),
    .fallbackEn(fallbackEn), .inhibit(inhibit), .delayCoarse(delayCoarse),
    .delayHigh(delayHigh), .delayFine(delayFine), .chanPulse(chanPulse),
    .fineTap(fineTap), .timingActive(timingActive), .armed(armed)
  );

  typedef struct packed {
    logic [23:0] dc;
    logic [2:0]  dh;
    logic [4:0]  df;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{dc: 24'd0, dh: 3'd0, df: 5'd3},
    '{dc: 24'd0, dh: 3'd7, df: 5'd31},
    '{dc: 24'd1, dh: 3'd0, df: 5'd0},
    '{dc: 24'd1, dh: 3'd5, df: 5'd12},
    '{dc: 24'd3, dh: 3'd2, df: 5'd9},
    '{dc: 24'd2, dh: 3'd7, df: 5'd17}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doArm();
    armPulse = 1'b1; step(); armPulse = 1'b0;
  endtask

  task automatic doEnable();
    enableStrobe = 1'b1; step(); enableStrobe = 1'b0;
  endtask

  task automatic startRun(input int dc, input int dh, input int df);
    delayCoarse = 24'(dc); delayHigh = 3'(dh); delayFine = 5'(df);
    refEvent = 1'b1; step(); refEvent = 1'b0;
  endtask

  task automatic measure(output int lat, output int width, output int ok);
    lat = 0; width = 0; ok = 1;
    while (!chanPulse && lat < 5000) begin
      if (!timingActive) ok = 0;
      step(); lat++;
    end
    while (chanPulse && width < 5000) begin
      if (timingActive) ok = 0;
      step(); width++;
    end
  endtask

  task automatic quietFor(input int n, output int seen);
    seen = 0;
    for (int k = 0; k < n; k++) begin
      if (chanPulse || timingActive) seen = 1;
      step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    int lat, width, ok, seen;
    step(); step();
    // R1 reset state
    chk("R1 pulse", int'(chanPulse), 0);
    chk("R1 active", int'(timingActive), 0);
    chk("R1 armed", int'(armed), 0);
    rstN = 1'b1;
    step();
    // R1: disabled after reset, so an armed reference is ignored
    doArm();
    chk("R2 armed", int'(armed), 1);
    startRun(0, 1, 0);
    quietFor(10, seen);
    chk("R1 R3 disabled ignores ref", seen, 0);

    doEnable();
    // Vector table: arm, reference, delay, width, trim, disarm
    for (int i = 0; i < NVEC; i++) begin
      doArm();
      startRun(int'(VECS[i].dc), int'(VECS[i].dh), int'(VECS[i].df));
      measure(lat, width, ok);
      chk("R4 latency", lat, 7 * int'(VECS[i].dc) + int'(VECS[i].dh) + 1);
      chk("R6 width", width, 56);
      chk("R5 status", ok, 1);
      chk("R8 fineTap", int'(fineTap), int'(VECS[i].df));
      chk("R7 disarmed", int'(armed), 0);
    end

    // R7: no re-arm, reference ignored
    startRun(0, 2, 1);
    quietFor(12, seen);
    chk("R7 unarmed ref ignored", seen, 0);

    // R8: inputs changed mid-count
    doArm();
    startRun(1, 2, 5);
    delayCoarse = 24'd5; delayHigh = 3'd0; delayFine = 5'd30;
    measure(lat, width, ok);
    chk("R8 latency held", lat, 10);
    chk("R8 tap held", int'(fineTap), 5);

    // R10: inhibit aborts a count and keeps armed
    doArm();
    startRun(2, 0, 0);
    step(); step(); step(); step();
    inhibit = 1'b1; step(); inhibit = 1'b0;
    chk("R10 abort", int'(timingActive), 0);
    quietFor(30, seen);
    chk("R10 no pulse after abort", seen, 0);
    chk("R10 armed kept", int'(armed), 1);

    // R10: inhibit during pulse forces output low
    startRun(0, 0, 0);
    step();
    chk("R10 pulse up", int'(chanPulse), 1);
    inhibit = 1'b1; #1;
    chk("R10 forced low", int'(chanPulse), 0);
    step(); inhibit = 1'b0;
    quietFor(5, seen);
    chk("R10 pulse ended", seen, 0);

    // R11: disable aborts, armed kept
    doArm();
    startRun(2, 0, 0);
    step(); step(); step();
    disableStrobe = 1'b1; step(); disableStrobe = 1'b0;
    chk("R11 abort", int'(timingActive), 0);
    quietFor(25, seen);
    chk("R11 no pulse", seen, 0);
    chk("R11 armed kept", int'(armed), 1);

    // R11: simultaneous enable and disable leaves disabled
    enableStrobe = 1'b1; disableStrobe = 1'b1; step();
    enableStrobe = 1'b0; disableStrobe = 1'b0;
    startRun(0, 0, 0);
    quietFor(5, seen);
    chk("R11 disable wins", seen, 0);

    // R9: fallback off ignores end-of-cycle
    doEnable();
    fallbackEn = 1'b0;
    endCycleEvent = 1'b1; step(); endCycleEvent = 1'b0;
    quietFor(6, seen);
    chk("R9 fallback off", seen, 0);
    chk("R9 armed kept", int'(armed), 1);

    // R9: direct pulse
    fallbackEn = 1'b1;
    endCycleEvent = 1'b1; step(); endCycleEvent = 1'b0;
    width = 0;
    while (chanPulse && width < 100) begin step(); width++; end
    chk("R9 direct width", width, 5);
    chk("R9 disarm", int'(armed), 0);

    // R9: not armed, end-of-cycle ignored
    endCycleEvent = 1'b1; step(); endCycleEvent = 1'b0;
    quietFor(6, seen);
    chk("R9 unarmed ignored", seen, 0);

    // R12: reference wins over end-of-cycle
    doArm();
    delayCoarse = 24'd0; delayHigh = 3'd3; delayFine = 5'd4;
    refEvent = 1'b1; endCycleEvent = 1'b1; step();
    refEvent = 1'b0; endCycleEvent = 1'b0;
    measure(lat, width, ok);
    chk("R12 latency", lat, 4);
    chk("R12 width", width, 56);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule